// File: doc/BRIEF.md
# Stereo Display Pixel Mapper

This block drives a flat panel in data-enable mode from two eye pixel streams, left and right, that wait in show-ahead buffers. A free-running horizontal counter and a vertical counter trace out every frame, blanking included. Data enable is high only where both counters are inside their active ranges. In each active cycle the block picks one eye, pops one pixel from that eye's buffer with a read strobe, and registers the pixel towards the panel.

There are two views. The side-by-side view puts the left image on the left half of each line and the right image on the right half, so each eye is read at full rate for half a line. The column-interleaved view serves an autostereoscopic panel. Active columns are numbered from 1, odd columns carry left pixels and even columns carry right pixels, so each eye is read every other cycle across the whole line and its image is squeezed horizontally to half width. A view change requested at any time is applied only at the next frame boundary, so a frame never mixes the two layouts.

Active sizes and porch and sync lengths are parameters. The defaults give a 1024x768 active area; an 800x600 panel needs only other parameter values.

Top module: `stereo_pix_mapper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, de_o is 0, pix_o is 0 and both read strobes are 0.
- R2: One line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK cycles, and de_o is high for exactly H_ACTIVE consecutive cycles in each active line.
- R3: A frame has V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines. de_o is high only in the first V_ACTIVE lines of a frame.
- R4: de_o is the AND of the horizontal active term and the vertical active term, taken from the counters one cycle earlier.
- R5: pix_o is all zeros in every cycle where de_o is 0.
- R6: When mode_3d_i is 0 (side-by-side), left_rd_o is high for active columns 0 to H_ACTIVE/2-1 and right_rd_o for the rest of the active line, counting columns from 0.
- R7: When mode_3d_i is 1 (interleaved), numbering active columns from 1, odd columns take the left pixel and even columns take the right pixel, so each active line starts with a left pixel.
- R8: In interleaved mode each eye's strobe is high only in its own columns and never in two cycles in a row.
- R9: The view in use is the value of mode_3d_i sampled at the last cycle of a frame. It holds for the whole next frame, and it is side-by-side after reset until the first frame end.
- R10: The pixel presented on the strobed eye's input in a strobe cycle appears on pix_o, with de_o high, in the next cycle.
- R11: The two read strobes are never high together, and neither is high outside the active area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_3d_i | input | 1 | Requested view: 0 side-by-side, 1 column-interleaved |
| left_pix_i | input | PW | Head of the left-eye buffer |
| right_pix_i | input | PW | Head of the right-eye buffer |
| left_rd_o | output | 1 | Pops the left-eye buffer this cycle |
| right_rd_o | output | 1 | Pops the right-eye buffer this cycle |
| de_o | output | 1 | Data enable to the panel |
| pix_o | output | PW | Pixel to the panel, zero when de_o is low |

## Verification
Each cycle the bench presents fresh random words on both eye inputs. A pixel routed from the wrong eye, or from the wrong cycle, therefore shows up at once on pix_o. The stimulus runs whole frames in side-by-side mode, then whole frames in interleaved mode, then a period where the view request toggles at random points, including mid-line and mid-frame. This separates a correct frame-boundary latch from an immediate switch. One frame holds both inputs at all ones, so blanking output of zero cannot be confused with zero data. A reset in the middle of a line, with interleaved mode requested, checks the return to the reset state and to side-by-side view for the first frame.

// File: rtl/stmap_pkg.sv
`timescale 1ns/1ps
package stmap_pkg;

    typedef enum logic {
        MODE_SBS = 1'b0,
        MODE_COL = 1'b1
    } view_mode_e;

    typedef enum logic [1:0] {
        EYE_NONE  = 2'd0,
        EYE_LEFT  = 2'd1,
        EYE_RIGHT = 2'd2
    } eye_e;

endpackage

// File: rtl/stmap_timing.sv
`timescale 1ns/1ps
module stmap_timing #(
    parameter int H_ACTIVE = 1024,
    parameter int H_TOTAL  = 1344,
    parameter int V_ACTIVE = 768,
    parameter int V_TOTAL  = 806,
    parameter int HW       = $clog2(H_TOTAL),
    parameter int VW       = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output logic          line_act,
    output logic          row_act,
    output logic          frame_end
);

    localparam logic [HW-1:0] H_LAST_C = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST_C = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] H_ACT_C  = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_ACT_C  = VW'(V_ACTIVE);

    typedef struct packed {
        logic          run;
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } tim_state_t;

    tim_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!s_q.run) begin
            s_d.run = 1'b1;
        end else if (s_q.h == H_LAST_C) begin
            s_d.h = '0;
            if (s_q.v == V_LAST_C) begin
                s_d.v = '0;
            end else begin
                s_d.v = s_q.v + 1'b1;
            end
        end else begin
            s_d.h = s_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign h_cnt     = s_q.h;
    assign v_cnt     = s_q.v;
    assign line_act  = s_q.run && (s_q.h < H_ACT_C);
    assign row_act   = s_q.v < V_ACT_C;
    assign frame_end = s_q.run && (s_q.h == H_LAST_C) && (s_q.v == V_LAST_C);

endmodule

// File: rtl/stmap_mode.sv
`timescale 1ns/1ps
module stmap_mode
    import stmap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_req,
    input  logic       frame_end,
    output view_mode_e mode_act
);

    typedef struct packed {
        view_mode_e mode;
    } mode_state_t;

    mode_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (frame_end) begin
            s_d.mode = mode_req ? MODE_COL : MODE_SBS;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode <= MODE_SBS;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_act = s_q.mode;

endmodule

// File: rtl/stmap_colsel.sv
`timescale 1ns/1ps
module stmap_colsel
    import stmap_pkg::*;
#(
    parameter int H_ACTIVE = 1024,
    parameter int HW       = 11
) (
    input  logic [HW-1:0] h_cnt,
    input  logic          active,
    input  view_mode_e    mode,
    output eye_e          eye
);

    localparam logic [HW-1:0] HALF_C = HW'(H_ACTIVE / 2);

    always_comb begin
        eye = EYE_NONE;
        if (active) begin
            if (mode == MODE_COL) begin
                // column number h_cnt+1: odd numbers have h_cnt[0]==0
                eye = h_cnt[0] ? EYE_RIGHT : EYE_LEFT;
            end else begin
                eye = (h_cnt < HALF_C) ? EYE_LEFT : EYE_RIGHT;
            end
        end
    end

endmodule

// File: rtl/stmap_pixout.sv
`timescale 1ns/1ps
module stmap_pixout
    import stmap_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  eye_e          eye,
    input  logic [PW-1:0] left_pix,
    input  logic [PW-1:0] right_pix,
    output logic          de,
    output logic [PW-1:0] pix
);

    typedef struct packed {
        logic          de;
        logic [PW-1:0] pix;
    } out_state_t;

    out_state_t s_d, s_q;

    always_comb begin
        s_d.de  = 1'b0;
        s_d.pix = '0;
        unique case (eye)
            EYE_LEFT: begin
                s_d.de  = 1'b1;
                s_d.pix = left_pix;
            end
            EYE_RIGHT: begin
                s_d.de  = 1'b1;
                s_d.pix = right_pix;
            end
            default: begin
                s_d.de  = 1'b0;
                s_d.pix = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign de  = s_q.de;
    assign pix = s_q.pix;

endmodule

// File: rtl/stereo_pix_mapper.sv
`timescale 1ns/1ps
module stereo_pix_mapper
    import stmap_pkg::*;
#(
    parameter int PW       = 16,
    parameter int H_ACTIVE = 1024,
    parameter int H_FRONT  = 24,
    parameter int H_SYNC   = 136,
    parameter int H_BACK   = 160,
    parameter int V_ACTIVE = 768,
    parameter int V_FRONT  = 3,
    parameter int V_SYNC   = 6,
    parameter int V_BACK   = 29
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_3d_i,
    input  logic [PW-1:0] left_pix_i,
    input  logic [PW-1:0] right_pix_i,
    output logic          left_rd_o,
    output logic          right_rd_o,
    output logic          de_o,
    output logic [PW-1:0] pix_o
);

    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);

    logic [HW-1:0] h_cnt_w;
    logic [VW-1:0] v_cnt_w;
    logic          line_act_w;
    logic          row_act_w;
    logic          frame_end_w;
    logic          active_w;
    view_mode_e    mode_w;
    eye_e          eye_w;

    stmap_timing #(
        .H_ACTIVE (H_ACTIVE),
        .H_TOTAL  (H_TOTAL),
        .V_ACTIVE (V_ACTIVE),
        .V_TOTAL  (V_TOTAL),
        .HW       (HW),
        .VW       (VW)
    ) u_tim (
        .clk       (clk),
        .rst_n     (rst_n),
        .h_cnt     (h_cnt_w),
        .v_cnt     (v_cnt_w),
        .line_act  (line_act_w),
        .row_act   (row_act_w),
        .frame_end (frame_end_w)
    );

    assign active_w = line_act_w & row_act_w;

    stmap_mode u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_req  (mode_3d_i),
        .frame_end (frame_end_w),
        .mode_act  (mode_w)
    );

    stmap_colsel #(
        .H_ACTIVE (H_ACTIVE),
        .HW       (HW)
    ) u_sel (
        .h_cnt  (h_cnt_w),
        .active (active_w),
        .mode   (mode_w),
        .eye    (eye_w)
    );

    assign left_rd_o  = (eye_w == EYE_LEFT);
    assign right_rd_o = (eye_w == EYE_RIGHT);

    stmap_pixout #(
        .PW (PW)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .eye       (eye_w),
        .left_pix  (left_pix_i),
        .right_pix (right_pix_i),
        .de        (de_o),
        .pix       (pix_o)
    );

endmodule

// File: rtl/stmap_chk.sv
`timescale 1ns/1ps
module stmap_chk
    import stmap_pkg::*;
#(
    parameter int PW     = 16,
    parameter int HW     = 11,
    parameter int VW     = 10,
    parameter int H_LAST = 1343,
    parameter int V_LAST = 805
) (
    input logic          clk,
    input logic          rst_n,
    input view_mode_e    mode_act,
    input logic          frame_end,
    input logic [HW-1:0] h_cnt,
    input logic [VW-1:0] v_cnt,
    input logic          rd_l,
    input logic          rd_r,
    input logic          de,
    input logic [PW-1:0] pix
);

    localparam logic [HW-1:0] H_LAST_C = HW'(H_LAST);
    localparam logic [VW-1:0] V_LAST_C = VW'(V_LAST);

    assert_rd_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_l && rd_r));

    assert_pix_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (pix == '0));

    assert_rd_to_de_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_l || rd_r) |=> de);

    assert_idle_to_blank_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_l || rd_r) |=> !de);

    assert_col_alt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_act == MODE_COL && rd_l) |=> !rd_l);

    assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_act) |-> $past(frame_end));

    assert_h_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        h_cnt <= H_LAST_C);

    assert_v_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        v_cnt <= V_LAST_C);

endmodule

bind stereo_pix_mapper stmap_chk #(
    .PW     (PW),
    .HW     (HW),
    .VW     (VW),
    .H_LAST (H_TOTAL - 1),
    .V_LAST (V_TOTAL - 1)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_act  (mode_w),
    .frame_end (frame_end_w),
    .h_cnt     (h_cnt_w),
    .v_cnt     (v_cnt_w),
    .rd_l      (left_rd_o),
    .rd_r      (right_rd_o),
    .de        (de_o),
    .pix       (pix_o)
);

// File: tb/sim_stereo_pix_mapper.sv
`timescale 1ns/1ps
module sim_stereo_pix_mapper;

    localparam int PW = 16;
    localparam int HA = 16, HF = 2, HS = 3, HB = 4;
    localparam int VA = 6,  VF = 1, VS = 2, VB = 2;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int FRAME = HT * VT;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_3d_i = 1'b0;
    logic [PW-1:0] left_pix_i = '0;
    logic [PW-1:0] right_pix_i = '0;
    logic          left_rd_o, right_rd_o, de_o;
    logic [PW-1:0] pix_o;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit fixed_data = 0;
    bit done = 0;

    // bench reference state
    int m_run = 0, m_h = 0, m_v = 0, m_mode = 0;
    int exp_de = 0;
    logic [PW-1:0] exp_pix = '0;
    int de_run = 0;

    stereo_pix_mapper #(
        .PW(PW), .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .mode_3d_i(mode_3d_i),
        .left_pix_i(left_pix_i), .right_pix_i(right_pix_i),
        .left_rd_o(left_rd_o), .right_rd_o(right_rd_o),
        .de_o(de_o), .pix_o(pix_o)
    );

    always #10 clk = ~clk;

    // 0 none, 1 left, 2 right
    function automatic int eye_of(int run, int h, int v, int mode);
        if (run == 0 || h >= HA || v >= VA) return 0;
        if (mode != 0) return (h % 2 == 0) ? 1 : 2;
        return (h < HA / 2) ? 1 : 2;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h (h=%0d v=%0d t=%0t)",
                     req, act, exp, m_h, m_v, $time);
        end
    endtask

    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_run = 0; m_h = 0; m_v = 0; m_mode = 0;
            exp_de = 0; exp_pix = '0;
        end else begin
            case (eye_of(m_run, m_h, m_v, m_mode))
                1:       begin exp_de = 1; exp_pix = left_pix_i;  end
                2:       begin exp_de = 1; exp_pix = right_pix_i; end
                default: begin exp_de = 0; exp_pix = '0;          end
            endcase
            if (m_run == 0) begin
                m_run = 1;
            end else if (m_h == HT - 1) begin
                m_h = 0;
                if (m_v == VT - 1) begin
                    m_v = 0;
                    m_mode = mode_3d_i ? 1 : 0;
                end else begin
                    m_v++;
                end
            end else begin
                m_h++;
            end
        end
    end

    always @(negedge clk) begin
        if (started && !done) begin
            int e;
            string rtag;
            e = eye_of(m_run, m_h, m_v, m_mode);
            if (!rst_n || m_run == 0) begin
                // R1 reset state
                check(de_o == 1'b0 && pix_o == '0, "R1 de/pix", {de_o, pix_o}, 0);
                check(!left_rd_o && !right_rd_o, "R1 strobes", {left_rd_o, right_rd_o}, 0);
            end else begin
                if (m_mode != (mode_3d_i ? 1 : 0)) rtag = "R9 strobe";
                else if (m_mode != 0)              rtag = "R7 R8 strobe";
                else                               rtag = "R6 strobe";
                check(left_rd_o == (e == 1), rtag, left_rd_o, (e == 1));
                check(right_rd_o == (e == 2), rtag, right_rd_o, (e == 2));
                check(!(left_rd_o && right_rd_o) && (e != 0 || !(left_rd_o || right_rd_o)),
                      "R11 exclusive", {left_rd_o, right_rd_o}, e);
                check(de_o == exp_de[0], exp_de != 0 ? "R4 de" : "R3 de", de_o, exp_de);
                if (exp_de == 0)
                    check(pix_o == '0, "R5 blank pix", pix_o, 0);
                else
                    check(pix_o == exp_pix, m_mode != 0 ? "R7 R10 pix" : "R6 R10 pix",
                          pix_o, exp_pix);
            end
            // R2 length of each DE burst
            if (!rst_n) begin
                de_run = 0;
            end else if (de_o) begin
                de_run++;
            end else if (de_run != 0) begin
                check(de_run == HA, "R2 burst", de_run, HA);
                de_run = 0;
            end
        end
    end

    task automatic step(int n, int toggle_odds);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fixed_data) begin
                left_pix_i  = '1;
                right_pix_i = '1;
            end else begin
                left_pix_i  = PW'($urandom);
                right_pix_i = PW'($urandom);
            end
            if (toggle_odds != 0 && ($urandom % toggle_odds) == 0)
                mode_3d_i = ~mode_3d_i;
        end
    endtask

    initial begin
        void'($urandom(32'd7331));
        rst_n = 1'b0;
        step(4, 0);
        rst_n = 1'b1;
        // side-by-side frames
        step(2 * FRAME, 0);
        // request interleave mid-frame, applies at next frame
        step(FRAME / 2 + 3, 0);
        mode_3d_i = 1'b1;
        step(3 * FRAME, 0);
        // all-ones data: blanking zero is distinct from data
        fixed_data = 1'b1;
        step(FRAME, 0);
        fixed_data = 1'b0;
        // random view toggles at arbitrary points
        step(20 * FRAME, 150);
        // reset mid-line with interleave requested
        mode_3d_i = 1'b1;
        step(HT * 2 + 5, 0);
        rst_n = 1'b0;
        step(3, 0);
        rst_n = 1'b1;
        step(3 * FRAME, 0);
        mode_3d_i = 1'b0;
        step(2 * FRAME, 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        done = 1'b1;
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule